// File: doc/BRIEF.md
# Tap Histogram Accumulator

This block gathers calibration statistics for a tapped-delay-line time-to-digital converter. It is fed with pulses whose arrival times are random with respect to the reference clock. Each accepted snapshot of the line is an M-bit tap vector. Every bit that is 1 adds one count to the bin that belongs to its tap, so over a long run the bins form an M-bin histogram. Software later sorts and differences this histogram to recover the tap order and the tap delays.

Each vector is also sorted into one of three classes by counting its 0/1 boundaries. A vector with no boundary (all zeros or all ones) is a missed edge. A vector with exactly one boundary is an observed edge. A vector with two or more boundaries is a jitter-induced leap. Software uses the ratio of observed to missed events to estimate the span of the line relative to the clock period.

A synchronous clear starts a run, and the enable input gates accumulation. A registered address/data port reads back the bins and the three class counters at any time.

Top module: `tap_hist_acc`

## Requirements
- R1: For every accepted vector, bin n grows by one when tap bit n is 1 and keeps its value when tap bit n is 0.
- R2: A vector is accepted on a rising clock edge when vld_i and en_i are high and clr_i is low. One vector is taken per cycle, and a new vector may arrive on every cycle.
- R3: An accepted vector with no 0/1 boundary between neighbouring taps (all zeros or all ones) adds one to the missed counter and to no other class counter.
- R4: An accepted vector with exactly one boundary between neighbouring taps adds one to the observed counter only.
- R5: An accepted vector with two or more boundaries adds one to the leap counter only, and its bits are still added to the bins.
- R6: Bins (BIN_W bits) and class counters (CNT_W bits) stop at their all-ones value and never wrap.
- R7: sat_o goes high after any accepted vector that would have incremented a bin or class counter that is already at its maximum. It stays high until a clear.
- R8: clr_i high on a rising edge zeroes all bins, all class counters and sat_o in that cycle. A vector presented in the same cycle is dropped.
- R9: With en_i low or vld_i low, taps_i changes no bin, no counter and not sat_o.
- R10: rd_data_o, zero-extended, shows the value at rd_addr_i one cycle after the address is presented. The address map is: 0..TAPS-1 for bin n, TAPS for the observed counter, TAPS+1 for the missed counter, TAPS+2 for the leap counter, and zero for any higher address.
- R11: Changing rd_addr_i while vectors stream in leaves the accumulated totals unchanged.
- R12: After reset, every bin, every counter and sat_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of bins, counters and flag |
| en_i | input | 1 | Accumulation enable |
| vld_i | input | 1 | Tap vector valid strobe |
| taps_i | input | TAPS | Snapshot of the delay-line taps |
| rd_addr_i | input | ADDR_W | Read address (bins, then observed, missed, leap) |
| rd_data_o | output | RD_W | Registered read data, zero-extended |
| sat_o | output | 1 | Sticky flag: some increment was clipped |

## Verification
The bench uses a six-tap, four-bit-bin configuration. A short sweep of vectors 0 to 20 mixes all three boundary classes while keeping the bins below their limit, so a wrong class rule or bin mapping shows up without saturation hiding it. Two full sweeps of all 64 vectors then drive every bin past its maximum, which separates clipping from wrapping and sets the sticky flag; the read address changes every cycle during these sweeps. Vectors presented with the enable low, with the strobe low, or together with a clear show whether the gating and the clear priority leave the read-back state exactly as the model predicts.

// File: rtl/tap_hist_pkg.sv
package tap_hist_pkg;
  // Event class derived from the number of 0/1 boundaries in a tap vector
  typedef enum logic [1:0] {
    EV_MISS = 2'd0,
    EV_OBS  = 2'd1,
    EV_LEAP = 2'd2
  } ev_class_e;

  localparam int NUM_CLASSES = 3;
endpackage

// File: rtl/tap_classify.sv
module tap_classify
  import tap_hist_pkg::*;
#(
  parameter  int TAPS = 8,
  localparam int CW   = $clog2(TAPS) + 1
) (
  input  logic [TAPS-1:0] taps_i,
  output ev_class_e       cls_o
);
  logic [TAPS-2:0] bnd;
  logic [CW-1:0]   nbnd;

  always_comb begin
    bnd  = taps_i[TAPS-1:1] ^ taps_i[TAPS-2:0];
    nbnd = '0;
    for (int i = 0; i < TAPS - 1; i++) begin
      nbnd = nbnd + CW'(bnd[i]);
    end
    if (nbnd == '0) begin
      cls_o = EV_MISS;
    end else if (nbnd == CW'(1)) begin
      cls_o = EV_OBS;
    end else begin
      cls_o = EV_LEAP;
    end
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         drop_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         full, cnt_en;

  always_comb begin
    full   = &cnt_q;
    drop_o = inc_i & full & ~clr_i;
    cnt_en = clr_i | (inc_i & ~full);
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hist_read_mux.sv
module hist_read_mux #(
  parameter int TAPS   = 8,
  parameter int BIN_W  = 32,
  parameter int CNT_W  = 32,
  parameter int RD_W   = 32,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [TAPS*BIN_W-1:0]   bins_i,
  input  logic [CNT_W-1:0]        obs_i,
  input  logic [CNT_W-1:0]        miss_i,
  input  logic [CNT_W-1:0]        leap_i,
  output logic [RD_W-1:0]         data_o
);
  logic [RD_W-1:0] data_d, data_q;

  always_comb begin
    data_d = '0;
    for (int i = 0; i < TAPS; i++) begin
      if (addr_i == ADDR_W'(i)) begin
        data_d = RD_W'(bins_i[i*BIN_W +: BIN_W]);
      end
    end
    if (addr_i == ADDR_W'(TAPS)) begin
      data_d = RD_W'(obs_i);
    end
    if (addr_i == ADDR_W'(TAPS + 1)) begin
      data_d = RD_W'(miss_i);
    end
    if (addr_i == ADDR_W'(TAPS + 2)) begin
      data_d = RD_W'(leap_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else begin
      data_q <= data_d;
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/tap_hist_acc.sv
module tap_hist_acc
  import tap_hist_pkg::*;
#(
  parameter  int TAPS   = 8,
  parameter  int BIN_W  = 32,
  parameter  int CNT_W  = 32,
  localparam int RD_W   = (BIN_W > CNT_W) ? BIN_W : CNT_W,
  localparam int ADDR_W = $clog2(TAPS + NUM_CLASSES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              vld_i,
  input  logic [TAPS-1:0]   taps_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [RD_W-1:0]   rd_data_o,
  output logic              sat_o
);
  logic                   acc;
  ev_class_e              cls;
  logic [TAPS*BIN_W-1:0]  bin_flat;
  logic [TAPS-1:0]        bin_drop;
  logic [CNT_W-1:0]       ev_cnt [NUM_CLASSES];
  logic [NUM_CLASSES-1:0] ev_drop;
  logic [CNT_W-1:0]       obs_cnt, miss_cnt, leap_cnt;
  logic                   sat_q, sat_d, sat_en, hit;

  always_comb begin
    acc = en_i & vld_i & ~clr_i;
  end

  tap_classify #(.TAPS(TAPS)) u_cls (
    .taps_i (taps_i),
    .cls_o  (cls)
  );

  // one saturating counter per tap
  for (genvar g = 0; g < TAPS; g++) begin : g_bin
    sat_counter #(.W(BIN_W)) u_bin (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_i),
      .inc_i  (acc & taps_i[g]),
      .cnt_o  (bin_flat[g*BIN_W +: BIN_W]),
      .drop_o (bin_drop[g])
    );
  end

  // one saturating counter per event class
  for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_ev
    sat_counter #(.W(CNT_W)) u_ev (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_i),
      .inc_i  (acc && (cls == ev_class_e'(k))),
      .cnt_o  (ev_cnt[k]),
      .drop_o (ev_drop[k])
    );
  end

  always_comb begin
    obs_cnt  = ev_cnt[EV_OBS];
    miss_cnt = ev_cnt[EV_MISS];
    leap_cnt = ev_cnt[EV_LEAP];
  end

  // sticky clipped-increment flag: next state and register
  always_comb begin
    hit    = (|bin_drop) | (|ev_drop);
    sat_en = clr_i | hit;
    sat_d  = ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sat_q <= 1'b0;
    end else if (sat_en) begin
      sat_q <= sat_d;
    end
  end

  assign sat_o = sat_q;

  hist_read_mux #(
    .TAPS   (TAPS),
    .BIN_W  (BIN_W),
    .CNT_W  (CNT_W),
    .RD_W   (RD_W),
    .ADDR_W (ADDR_W)
  ) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_i (rd_addr_i),
    .bins_i (bin_flat),
    .obs_i  (obs_cnt),
    .miss_i (miss_cnt),
    .leap_i (leap_cnt),
    .data_o (rd_data_o)
  );
endmodule

// File: rtl/tap_hist_chk.sv
module tap_hist_chk #(
  parameter int TAPS  = 8,
  parameter int BIN_W = 32,
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  clr_i,
  input logic                  en_i,
  input logic                  vld_i,
  input logic [TAPS-1:0]       taps_i,
  input logic                  sat_o,
  input logic [TAPS*BIN_W-1:0] bin_flat,
  input logic [CNT_W-1:0]      obs_cnt,
  input logic [CNT_W-1:0]      miss_cnt,
  input logic [CNT_W-1:0]      leap_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  logic            take;
  logic [CNT_W+1:0] total;

  always_comb begin
    take  = en_i & vld_i & ~clr_i;
    total = (CNT_W+2)'(obs_cnt) + (CNT_W+2)'(miss_cnt) + (CNT_W+2)'(leap_cnt);
  end

  // R8: clear empties everything
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (obs_cnt == '0 && miss_cnt == '0 && leap_cnt == '0 && bin_flat == '0 && !sat_o));

  // R9: nothing moves without an accepted vector
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clr_i) |=> ($stable(bin_flat) && $stable(total) && $stable(sat_o)));

  // R2: each accepted vector lands in exactly one class counter
  p_one_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && obs_cnt != CMAX && miss_cnt != CMAX && leap_cnt != CMAX)
      |=> total == $past(total) + (CNT_W+2)'(1));

  // R3: a uniform vector counts as missed
  p_missed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (taps_i == '0 || taps_i == '1) && miss_cnt != CMAX)
      |=> miss_cnt == $past(miss_cnt) + CNT_W'(1));

  // R7: the flag is sticky until a clear
  p_sat_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_o && !clr_i) |=> sat_o);

  // R6: bins never decrease except through clear
  for (genvar g = 0; g < TAPS; g++) begin : g_mono
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> bin_flat[g*BIN_W +: BIN_W] >= $past(bin_flat[g*BIN_W +: BIN_W]));
  end
endmodule

bind tap_hist_acc tap_hist_chk #(
  .TAPS  (TAPS),
  .BIN_W (BIN_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_i    (clr_i),
  .en_i     (en_i),
  .vld_i    (vld_i),
  .taps_i   (taps_i),
  .sat_o    (sat_o),
  .bin_flat (bin_flat),
  .obs_cnt  (obs_cnt),
  .miss_cnt (miss_cnt),
  .leap_cnt (leap_cnt)
);

// File: tb/test_tap_hist_acc.sv
`timescale 1ns/1ps
module test_tap_hist_acc;
  localparam int  TAPS  = 6;
  localparam int  BIN_W = 4;
  localparam int  CNT_W = 8;
  localparam int  RD_W  = 8;
  localparam int  AW    = 4;
  localparam real TCLK  = 8.0;

  logic            clk;
  logic            rst_n;
  logic            clr_i, en_i, vld_i;
  logic [TAPS-1:0] taps_i;
  logic [AW-1:0]   rd_addr_i;
  logic [RD_W-1:0] rd_data_o;
  logic            sat_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  int exp_bin [TAPS];
  int exp_obs, exp_miss, exp_leap;
  bit exp_sat;

  tap_hist_acc #(.TAPS(TAPS), .BIN_W(BIN_W), .CNT_W(CNT_W)) i_tap_hist_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .en_i      (en_i),
    .vld_i     (vld_i),
    .taps_i    (taps_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .sat_o     (sat_o)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < TAPS; i++) exp_bin[i] = 0;
    exp_obs = 0; exp_miss = 0; exp_leap = 0; exp_sat = 0;
  endtask

  function automatic int bump(input int v, input int maxv, inout bit s);
    if (v == maxv) begin
      s = 1;
      return v;
    end
    return v + 1;
  endfunction

  task automatic model_take(input logic [TAPS-1:0] v);
    int nb;
    nb = 0;
    for (int i = 0; i < TAPS - 1; i++) if (v[i] != v[i+1]) nb++;
    for (int i = 0; i < TAPS; i++) if (v[i]) exp_bin[i] = bump(exp_bin[i], 15, exp_sat);
    if (nb == 0)      exp_miss = bump(exp_miss, 255, exp_sat);
    else if (nb == 1) exp_obs  = bump(exp_obs, 255, exp_sat);
    else              exp_leap = bump(exp_leap, 255, exp_sat);
  endtask

  // present one cycle of stimulus; the model follows the acceptance rule
  task automatic push(input logic [TAPS-1:0] v, input logic en, input logic vld,
                      input logic clr, input logic [AW-1:0] ra);
    @(negedge clk);
    taps_i = v; en_i = en; vld_i = vld; clr_i = clr; rd_addr_i = ra;
    if (clr) model_clear();
    else if (en && vld) model_take(v);
  endtask

  task automatic idle();
    @(negedge clk);
    vld_i = 0; clr_i = 0; en_i = 0;
  endtask

  function automatic int expect_at(input int a);
    if (a < TAPS) return exp_bin[a];
    if (a == TAPS) return exp_obs;
    if (a == TAPS + 1) return exp_miss;
    if (a == TAPS + 2) return exp_leap;
    return 0;
  endfunction

  task automatic read_all(input string req);
    for (int a = 0; a < (1 << AW); a++) begin
      @(negedge clk);
      rd_addr_i = AW'(a);
      @(negedge clk);
      check(req, $sformatf("addr %0d", a), int'(rd_data_o), expect_at(a));
    end
  endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clr_i = 0; en_i = 0; vld_i = 0; taps_i = '0; rd_addr_i = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12: reset state; R10: unmapped addresses read zero
    check("R12", "sat_o after reset", int'(sat_o), 0);
    read_all("R12/R10");

    // R1 R2 R3 R4 R5: back-to-back vectors 0..20 covering all classes
    for (int v = 0; v <= 20; v++) push(TAPS'(v), 1, 1, 0, '0);
    idle();
    read_all("R1/R2/R3/R4/R5");
    check("R7", "sat_o below limit", int'(sat_o), 0);

    // R9: enable low, then strobe low
    for (int v = 40; v < 48; v++) push(TAPS'(v), 0, 1, 0, '0);
    for (int v = 48; v < 56; v++) push(TAPS'(v), 1, 0, 0, '0);
    idle();
    read_all("R9");

    // R8: clear together with a valid vector drops the vector
    push(6'b000111, 1, 1, 1, '0);
    idle();
    read_all("R8");

    // R6 R7 R11: two full sweeps with the read address moving every cycle
    for (int r = 0; r < 2; r++)
      for (int v = 0; v < 64; v++) push(TAPS'(v), 1, 1, 0, AW'(v % 16));
    idle();
    read_all("R6/R11");
    check("R7", "sat_o after clipping", int'(sat_o), int'(exp_sat));
    check("R7", "sat_o expected set", int'(exp_sat), 1);

    // R8: clear drops the flag and all statistics
    push('0, 0, 0, 1, '0);
    idle();
    check("R8", "sat_o after clear", int'(sat_o), 0);
    read_all("R8");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule